// File: doc/BRIEF.md
# Address-Match Read Redirection Traps

This block sits on the read-address path of an emulated serial flash. It is used to exercise check-then-use flows in target firmware. It holds four independent trap entries. Each entry has a start address, a care mask and a replacement base. When an entry is armed, it compares every incoming read start address against its start value, using only the bits where its mask holds a 1.

The first matching read of an armed entry goes through unchanged and marks that entry as triggered. Every later matching read is steered to the replacement region. The address bits outside the mask are kept. A trap-fired event, carrying the entry index, goes to the bus logger. Redirection only reaches the memory path from the ninth byte of a read onward, because the first 8-byte burst has already been fetched from the original address. For that reason the block returns two addresses: a head address for the first burst and a tail address for the bytes after it.

Configuration arrives as a byte stream of sub-commands. The sub-command code byte comes first. An index byte follows where one applies, and the set command then carries three 24-bit values, most significant byte first.

Top module: `addr_trap_remap`

## Requirements
- R1: While `rst_ni` is low, all entries are disarmed and untriggered, `out_valid_o` and `fire_o` are 0, and all stored start, mask and replacement values are 0.
- R2: A read matches an armed entry when `(addr XOR start) AND mask` is zero. Address bits where the mask is 0 do not affect the match.
- R3: When an armed, untriggered entry matches a read, that read passes unchanged (`tail_addr_o` equals the read address and `fire_o` is 0), and the entry's bit in `triggered_o` is set by the same clock edge. A triggered bit is only ever set by a read.
- R4: When an armed, triggered entry matches a read, `tail_addr_o` becomes `(repl AND mask) OR (addr AND NOT mask)`, `fire_o` is 1 and `fire_idx_o` gives the entry index.
- R5: `head_addr_o` always equals the original read address, whether or not the read is redirected.
- R6: When several armed, triggered entries match the same read, the entry with the lowest index is used.
- R7: A disarmed entry never matches, and a read never changes its triggered bit.
- R8: The sub-command is coded as follows: byte 0x02 then an index byte arms that entry; 0x03 then an index byte disarms it; 0x04 then an index byte clears only its triggered bit. A command takes effect on the second rising edge after its last byte is accepted.
- R9: The single byte 0x05 disarms all entries and clears all triggered bits. Stored start, mask and replacement values are kept.
- R10: A sub-command byte outside 0x01 to 0x05 is dropped, and the parser waits for the next sub-command. An index byte of 4 or more makes the command have no effect.
- R11: `out_valid_o` is high in exactly the cycle after each cycle in which `rd_valid_i` is high.
- R12: The set command is byte 0x01, then an index byte, then start, mask and replacement as 3 bytes each, most significant byte first. It loads the entry's values and clears its triggered bit, and leaves its armed bit as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_valid_i | input | 1 | Read start strobe |
| rd_addr_i | input | 24 | Read start byte address |
| cfg_valid_i | input | 1 | Configuration byte strobe |
| cfg_byte_i | input | 8 | Configuration byte |
| out_valid_o | output | 1 | Result strobe, one cycle after a read |
| head_addr_o | output | 24 | Address for the first 8-byte burst (always the original) |
| tail_addr_o | output | 24 | Address for the bytes from the ninth onward |
| fire_o | output | 1 | Trap-fired event for the logger |
| fire_idx_o | output | 2 | Index of the entry that fired |
| armed_o | output | 4 | Armed bit per entry |
| triggered_o | output | 4 | Triggered bit per entry |

## Verification
The assertions assume that a read strobe is never left high through a reset release, and that a triggered bit can only rise after a read. So no command may set a triggered bit, and no setup step may raise one without a read. The firing check compares the fired entry against the armed and triggered state of the previous cycle. This assumes that a reconfiguring command and a read never land on the same edge. The stimulus keeps them apart: it always lets a command take effect before it issues the next read. It also holds the read strobe at zero while reset is applied.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_SET     = 3'd1,
    CMD_ARM     = 3'd2,
    CMD_DISARM  = 3'd3,
    CMD_CLR     = 3'd4,
    CMD_CLR_ALL = 3'd5
  } trap_cmd_e;

  localparam logic [7:0] SUB_FIRST = 8'h01;
  localparam logic [7:0] SUB_LAST_IDX = 8'h04;
  localparam logic [7:0] SUB_CLR_ALL = 8'h05;
endpackage

// File: rtl/trap_cfg_rx.sv
module trap_cfg_rx
  import trap_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int ADDR_W    = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 byte_valid_i,
  input  logic [7:0]           byte_i,
  output logic                 cmd_valid_o,
  output trap_cmd_e            cmd_op_o,
  output logic [N_ENTRIES-1:0] cmd_sel_o,
  output logic [ADDR_W-1:0]    cmd_start_o,
  output logic [ADDR_W-1:0]    cmd_mask_o,
  output logic [ADDR_W-1:0]    cmd_repl_o
);
  localparam int ARG_W     = 3 * ADDR_W;
  localparam int ARG_BYTES = ARG_W / 8;
  localparam int CNT_W     = $clog2(ARG_BYTES + 1);

  typedef enum logic [1:0] {ST_OP, ST_IDX, ST_ARG} rx_st_e;

  rx_st_e                st_q, st_d;
  trap_cmd_e             op_q, op_d;
  logic [7:0]            idx_q, idx_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [ARG_W-1:0]      arg_q, arg_d, arg_shift;
  logic                  emit;
  trap_cmd_e             emit_op;
  logic [N_ENTRIES-1:0]  emit_sel;
  logic                  valid_q;
  trap_cmd_e             cop_q;
  logic [N_ENTRIES-1:0]  csel_q;

  function automatic logic [N_ENTRIES-1:0] idx_onehot(input logic [7:0] b);
    logic [N_ENTRIES-1:0] r;
    for (int i = 0; i < N_ENTRIES; i++) r[i] = (b == 8'(i));
    return r;
  endfunction

  assign arg_shift = {arg_q[ARG_W-9:0], byte_i};

  always_comb begin
    st_d     = st_q;
    op_d     = op_q;
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    arg_d    = arg_q;
    emit     = 1'b0;
    emit_op  = CMD_NONE;
    emit_sel = '0;
    if (byte_valid_i) begin
      unique case (st_q)
        ST_OP: begin
          if (byte_i >= SUB_FIRST && byte_i <= SUB_LAST_IDX) begin
            op_d = trap_cmd_e'(byte_i[2:0]);
            st_d = ST_IDX;
          end else if (byte_i == SUB_CLR_ALL) begin
            emit     = 1'b1;
            emit_op  = CMD_CLR_ALL;
            emit_sel = '1;
          end
        end
        ST_IDX: begin
          idx_d = byte_i;
          if (op_q == CMD_SET) begin
            st_d  = ST_ARG;
            cnt_d = '0;
          end else begin
            emit     = 1'b1;
            emit_op  = op_q;
            emit_sel = idx_onehot(byte_i);
            st_d     = ST_OP;
          end
        end
        ST_ARG: begin
          arg_d = arg_shift;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ARG_BYTES - 1)) begin
            emit     = 1'b1;
            emit_op  = CMD_SET;
            emit_sel = idx_onehot(idx_q);
            st_d     = ST_OP;
          end
        end
        default: st_d = ST_OP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_OP;
      op_q    <= CMD_NONE;
      idx_q   <= '0;
      cnt_q   <= '0;
      arg_q   <= '0;
      valid_q <= 1'b0;
      cop_q   <= CMD_NONE;
      csel_q  <= '0;
    end else begin
      st_q    <= st_d;
      op_q    <= op_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      arg_q   <= arg_d;
      valid_q <= emit;
      cop_q   <= emit_op;
      csel_q  <= emit_sel;
    end
  end

  assign cmd_valid_o = valid_q;
  assign cmd_op_o    = cop_q;
  assign cmd_sel_o   = csel_q;
  // first value sent lands in the top slice
  assign cmd_start_o = arg_q[ARG_W-1 -: ADDR_W];
  assign cmd_mask_o  = arg_q[2*ADDR_W-1 -: ADDR_W];
  assign cmd_repl_o  = arg_q[ADDR_W-1:0];
endmodule

// File: rtl/trap_entry.sv
module trap_entry
  import trap_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  trap_cmd_e         cmd_op_i,
  input  logic              cmd_sel_i,
  input  logic [ADDR_W-1:0] cmd_start_i,
  input  logic [ADDR_W-1:0] cmd_mask_i,
  input  logic [ADDR_W-1:0] cmd_repl_i,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              armed_o,
  output logic              trig_o,
  output logic              redir_o,
  output logic [ADDR_W-1:0] remap_o
);
  logic [ADDR_W-1:0] start_q, mask_q, repl_q;
  logic              armed_q, trig_q, hit;

  assign hit     = armed_q && (((rd_addr_i ^ start_q) & mask_q) == '0);
  assign redir_o = hit && trig_q;
  assign remap_o = (repl_q & mask_q) | (rd_addr_i & ~mask_q);
  assign armed_o = armed_q;
  assign trig_o  = trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      mask_q  <= '0;
      repl_q  <= '0;
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else if (cmd_valid_i && cmd_sel_i) begin
      // a command on this entry overrides a read in the same cycle
      unique case (cmd_op_i)
        CMD_SET: begin
          start_q <= cmd_start_i;
          mask_q  <= cmd_mask_i;
          repl_q  <= cmd_repl_i;
          trig_q  <= 1'b0;
        end
        CMD_ARM:    armed_q <= 1'b1;
        CMD_DISARM: armed_q <= 1'b0;
        CMD_CLR:    trig_q  <= 1'b0;
        CMD_CLR_ALL: begin
          armed_q <= 1'b0;
          trig_q  <= 1'b0;
        end
        default: ;
      endcase
    end else if (rd_valid_i && hit && !trig_q) begin
      trig_q <= 1'b1;
    end
  end
endmodule

// File: rtl/trap_pick.sv
module trap_pick #(
  parameter int N_ENTRIES = 4,
  parameter int ADDR_W    = 24,
  parameter int IDX_W     = 2
) (
  input  logic [N_ENTRIES-1:0] req_i,
  input  logic [ADDR_W-1:0]    addr_i [N_ENTRIES],
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [ADDR_W-1:0]    addr_o
);
  // walk downward so the lowest requesting index is assigned last
  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    addr_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o  = 1'b1;
        idx_o  = IDX_W'(i);
        addr_o = addr_i[i];
      end
    end
  end
endmodule

// File: rtl/addr_trap_remap.sv
module addr_trap_remap
  import trap_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int ADDR_W    = 24,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_valid_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  input  logic                 cfg_valid_i,
  input  logic [7:0]           cfg_byte_i,
  output logic                 out_valid_o,
  output logic [ADDR_W-1:0]    head_addr_o,
  output logic [ADDR_W-1:0]    tail_addr_o,
  output logic                 fire_o,
  output logic [IDX_W-1:0]     fire_idx_o,
  output logic [N_ENTRIES-1:0] armed_o,
  output logic [N_ENTRIES-1:0] triggered_o
);
  logic                 cmd_valid;
  trap_cmd_e            cmd_op;
  logic [N_ENTRIES-1:0] cmd_sel;
  logic [ADDR_W-1:0]    cmd_start, cmd_mask, cmd_repl;
  logic [N_ENTRIES-1:0] redir;
  logic [ADDR_W-1:0]    remap_w [N_ENTRIES];
  logic                 pick_any;
  logic [IDX_W-1:0]     pick_idx;
  logic [ADDR_W-1:0]    pick_addr;

  logic                 valid_q, fire_q;
  logic [ADDR_W-1:0]    head_q, tail_q;
  logic [IDX_W-1:0]     idx_q;

  trap_cfg_rx #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_valid_i(cfg_valid_i),
    .byte_i      (cfg_byte_i),
    .cmd_valid_o (cmd_valid),
    .cmd_op_o    (cmd_op),
    .cmd_sel_o   (cmd_sel),
    .cmd_start_o (cmd_start),
    .cmd_mask_o  (cmd_mask),
    .cmd_repl_o  (cmd_repl)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    trap_entry #(.ADDR_W(ADDR_W)) u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cmd_valid_i(cmd_valid),
      .cmd_op_i   (cmd_op),
      .cmd_sel_i  (cmd_sel[g]),
      .cmd_start_i(cmd_start),
      .cmd_mask_i (cmd_mask),
      .cmd_repl_i (cmd_repl),
      .rd_valid_i (rd_valid_i),
      .rd_addr_i  (rd_addr_i),
      .armed_o    (armed_o[g]),
      .trig_o     (triggered_o[g]),
      .redir_o    (redir[g]),
      .remap_o    (remap_w[g])
    );
  end

  trap_pick #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_pick (
    .req_i (redir),
    .addr_i(remap_w),
    .any_o (pick_any),
    .idx_o (pick_idx),
    .addr_o(pick_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      fire_q  <= 1'b0;
      head_q  <= '0;
      tail_q  <= '0;
      idx_q   <= '0;
    end else begin
      valid_q <= rd_valid_i;
      fire_q  <= rd_valid_i && pick_any;
      if (rd_valid_i) begin
        head_q <= rd_addr_i;
        tail_q <= pick_any ? pick_addr : rd_addr_i;
        idx_q  <= pick_idx;
      end
    end
  end

  assign out_valid_o = valid_q;
  assign fire_o      = fire_q;
  assign head_addr_o = head_q;
  assign tail_addr_o = tail_q;
  assign fire_idx_o  = idx_q;
endmodule

// File: rtl/addr_trap_remap_chk.sv
module addr_trap_remap_chk #(
  parameter int N_ENTRIES = 4,
  parameter int ADDR_W    = 24,
  parameter int IDX_W     = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rd_valid_i,
  input logic [ADDR_W-1:0]    rd_addr_i,
  input logic                 out_valid_o,
  input logic [ADDR_W-1:0]    head_addr_o,
  input logic [ADDR_W-1:0]    tail_addr_o,
  input logic                 fire_o,
  input logic [IDX_W-1:0]     fire_idx_o,
  input logic [N_ENTRIES-1:0] armed_o,
  input logic [N_ENTRIES-1:0] triggered_o
);
  logic [N_ENTRIES-1:0] armtrig_q, trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armtrig_q <= '0;
      trig_q    <= '0;
    end else begin
      armtrig_q <= armed_o & triggered_o;
      trig_q    <= triggered_o;
    end
  end

  AST_OUT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> out_valid_o); // R11
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> !out_valid_o); // R11
  AST_HEAD_IS_ORIGINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> (head_addr_o == $past(rd_addr_i))); // R5
  AST_FIRE_ONLY_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> out_valid_o); // R4
  AST_PASS_UNCHANGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !fire_o) |-> (tail_addr_o == head_addr_o)); // R3
  AST_FIRE_NEEDS_ARMED_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> armtrig_q[fire_idx_o]); // R7
  AST_TRIG_SET_BY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((triggered_o & ~trig_q) != '0) |-> $past(rd_valid_i)); // R3
endmodule

bind addr_trap_remap addr_trap_remap_chk #(
  .N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_valid_i (rd_valid_i),
  .rd_addr_i  (rd_addr_i),
  .out_valid_o(out_valid_o),
  .head_addr_o(head_addr_o),
  .tail_addr_o(tail_addr_o),
  .fire_o     (fire_o),
  .fire_idx_o (fire_idx_o),
  .armed_o    (armed_o),
  .triggered_o(triggered_o)
);

// File: tb/addr_trap_remap_bench.sv
module addr_trap_remap_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_valid_i = 1'b0;
  logic [23:0] rd_addr_i = '0;
  logic        cfg_valid_i = 1'b0;
  logic [7:0]  cfg_byte_i = '0;
  logic        out_valid_o, fire_o;
  logic [23:0] head_addr_o, tail_addr_o;
  logic [1:0]  fire_idx_o;
  logic [3:0]  armed_o, triggered_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  addr_trap_remap u_addr_trap_remap (.*);

  // reference model
  logic [23:0] m_start [4], m_mask [4], m_repl [4];
  bit          m_arm [4], m_trig [4];
  bit          e_valid, e_fire;
  int          e_idx;
  logic [23:0] e_head, e_tail;
  logic [7:0]  q [$];
  bit          pend;
  int          p_op, p_idx;
  logic [23:0] p_s, p_m, p_r;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 4; i++) begin
        m_start[i] = 0; m_mask[i] = 0; m_repl[i] = 0; m_arm[i] = 0; m_trig[i] = 0;
      end
      e_valid = 0; e_fire = 0; e_idx = 0; e_head = 0; e_tail = 0;
      q.delete(); pend = 0;
    end else begin
      bit new_trig [4];
      bit found;
      bit ap;
      for (int i = 0; i < 4; i++) new_trig[i] = m_trig[i];
      e_valid = rd_valid_i;
      e_fire = 0;
      found = 0;
      if (rd_valid_i) begin
        e_head = rd_addr_i;
        e_tail = rd_addr_i;
        for (int i = 0; i < 4; i++) begin
          if (m_arm[i] && (((rd_addr_i ^ m_start[i]) & m_mask[i]) == 0)) begin
            if (m_trig[i]) begin
              if (!found) begin
                found = 1; e_fire = 1; e_idx = i;
                e_tail = (m_repl[i] & m_mask[i]) | (rd_addr_i & ~m_mask[i]);
              end
            end else new_trig[i] = 1;
          end
        end
      end
      for (int i = 0; i < 4; i++) m_trig[i] = new_trig[i];
      ap = pend;
      pend = 0;
      if (ap) begin
        for (int i = 0; i < 4; i++) begin
          if (p_op == 5) begin m_arm[i] = 0; m_trig[i] = 0; end
          else if (i == p_idx) begin
            case (p_op)
              1: begin m_start[i] = p_s; m_mask[i] = p_m; m_repl[i] = p_r; m_trig[i] = 0; end
              2: m_arm[i] = 1;
              3: m_arm[i] = 0;
              4: m_trig[i] = 0;
              default: ;
            endcase
          end
        end
      end
      if (cfg_valid_i) begin
        q.push_back(cfg_byte_i);
        if (q[0] < 1 || q[0] > 5) q.delete();
        else if (q[0] == 5) begin pend = 1; p_op = 5; q.delete(); end
        else if (q[0] != 1 && q.size() == 2) begin
          if (q[1] < 4) begin pend = 1; p_op = q[0]; p_idx = q[1]; end
          q.delete();
        end else if (q[0] == 1 && q.size() == 11) begin
          if (q[1] < 4) begin
            pend = 1; p_op = 1; p_idx = q[1];
            p_s = {q[2], q[3], q[4]}; p_m = {q[5], q[6], q[7]}; p_r = {q[8], q[9], q[10]};
          end
          q.delete();
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      logic [3:0] ea, et;
      for (int i = 0; i < 4; i++) begin ea[i] = m_arm[i]; et[i] = m_trig[i]; end
      chk("R11 model out_valid", 32'(out_valid_o), 32'(e_valid));
      chk("R4 model fire", 32'(fire_o), 32'(e_fire));
      if (e_fire) chk("R6 model fire_idx", 32'(fire_idx_o), 32'(e_idx));
      if (e_valid) begin
        chk("R5 model head", 32'(head_addr_o), 32'(e_head));
        chk("R4 model tail", 32'(tail_addr_o), 32'(e_tail));
      end
      chk("R8 model armed", 32'(armed_o), 32'(ea));
      chk("R3 model triggered", 32'(triggered_o), 32'(et));
    end
  end

  task automatic report;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic cfg_byte(input logic [7:0] b);
    @(negedge clk_i);
    cfg_valid_i = 1'b1;
    cfg_byte_i = b;
  endtask

  task automatic cfg_end;
    @(negedge clk_i);
    cfg_valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic cfg_op(input logic [7:0] op, input logic [7:0] idx);
    cfg_byte(op);
    cfg_byte(idx);
    cfg_end();
  endtask

  task automatic cfg_set(input logic [7:0] idx, input logic [23:0] s, input logic [23:0] m,
                         input logic [23:0] r);
    cfg_byte(8'h01);
    cfg_byte(idx);
    for (int k = 2; k >= 0; k--) cfg_byte(s[k*8 +: 8]);
    for (int k = 2; k >= 0; k--) cfg_byte(m[k*8 +: 8]);
    for (int k = 2; k >= 0; k--) cfg_byte(r[k*8 +: 8]);
    cfg_end();
  endtask

  task automatic rd(input logic [23:0] a);
    @(negedge clk_i);
    rd_valid_i = 1'b1;
    rd_addr_i = a;
    @(negedge clk_i);
    rd_valid_i = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset armed", 32'(armed_o), 0);
    chk("R1 reset triggered", 32'(triggered_o), 0);
    chk("R1 reset valid", 32'(out_valid_o), 0);
    chk("R1 reset fire", 32'(fire_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    cfg_set(8'd1, 24'h001000, 24'hFFF000, 24'h101000);
    cfg_op(8'h02, 8'd1);
    chk("R8 arm entry1", 32'(armed_o), 32'h2);
    chk("R12 set leaves untriggered", 32'(triggered_o), 0);

    rd(24'h001234);
    chk("R11 valid after read", 32'(out_valid_o), 1);
    chk("R3 first pass no fire", 32'(fire_o), 0);
    chk("R3 first pass tail", 32'(tail_addr_o), 32'h001234);
    chk("R3 triggered set", 32'(triggered_o), 32'h2);

    rd(24'h001234);
    chk("R4 fire", 32'(fire_o), 1);
    chk("R4 fire idx", 32'(fire_idx_o), 1);
    chk("R4 tail remap", 32'(tail_addr_o), 32'h101234);
    chk("R5 head original", 32'(head_addr_o), 32'h001234);

    rd(24'h002000);
    chk("R2 cared bit differs", 32'(fire_o), 0);
    chk("R2 tail unchanged", 32'(tail_addr_o), 32'h002000);
    rd(24'h001FFF);
    chk("R2 dont-care bits match", 32'(tail_addr_o), 32'h101FFF);

    cfg_op(8'h04, 8'd1);
    chk("R8 reset one", 32'(triggered_o), 0);
    chk("R8 reset one keeps armed", 32'(armed_o), 32'h2);
    rd(24'h001000);
    chk("R8 read after reset passes", 32'(fire_o), 0);

    cfg_set(8'd0, 24'h000000, 24'hFF0000, 24'h330000);
    cfg_op(8'h02, 8'd0);
    chk("R8 armed both", 32'(armed_o), 32'h3);
    rd(24'h0010AA);
    chk("R6 only triggered fires", 32'(fire_idx_o), 1);
    chk("R3 entry0 triggered", 32'(triggered_o), 32'h3);
    rd(24'h001800);
    chk("R6 lowest index", 32'(fire_idx_o), 0);
    chk("R6 lowest tail", 32'(tail_addr_o), 32'h331800);

    cfg_op(8'h03, 8'd0);
    chk("R8 disarm", 32'(armed_o), 32'h2);
    rd(24'h001800);
    chk("R7 disarmed skipped", 32'(fire_idx_o), 1);
    chk("R7 disarmed tail", 32'(tail_addr_o), 32'h101800);
    rd(24'h00F000);
    chk("R7 no fire", 32'(fire_o), 0);
    chk("R7 flag kept", 32'(triggered_o), 32'h3);

    cfg_byte(8'h07);
    cfg_end();
    cfg_op(8'h02, 8'd2);
    chk("R10 bad code dropped", 32'(armed_o), 32'h6);
    cfg_op(8'h02, 8'd9);
    chk("R10 bad index", 32'(armed_o), 32'h6);

    cfg_set(8'd1, 24'h001000, 24'hFFF000, 24'h202000);
    chk("R12 set clears trig", 32'(triggered_o), 32'h1);
    chk("R12 set keeps armed", 32'(armed_o), 32'h6);
    rd(24'h001010);
    chk("R12 first pass", 32'(fire_o), 0);
    chk("R2 zero mask matches all", 32'(triggered_o), 32'h7);
    rd(24'h001010);
    chk("R12 new repl", 32'(tail_addr_o), 32'h202010);
    chk("R6 entry1 over entry2", 32'(fire_idx_o), 1);

    cfg_byte(8'h05);
    cfg_end();
    chk("R9 all disarmed", 32'(armed_o), 0);
    chk("R9 all cleared", 32'(triggered_o), 0);
    cfg_op(8'h02, 8'd1);
    rd(24'h001010);
    chk("R9 first pass again", 32'(fire_o), 0);
    rd(24'h001010);
    chk("R9 values kept", 32'(tail_addr_o), 32'h202010);
    @(negedge clk_i);
    chk("R11 valid drops", 32'(out_valid_o), 0);

    repeat (3) @(negedge clk_i);
    report();
  end
endmodule